// File: doc/BRIEF.md
# Snapshot Down-Counter Timer Bank

This block holds four 32-bit down-counting timer channels behind a small register port. The port has an address, a write strobe with write data, and a read strobe whose data comes back registered one cycle later. A channel decrements once per clock, but only while both the block-wide run bit and its own run bit are set. When an enabled channel steps past zero, it reloads from its programmed value in the same cycle. That step also bumps the channel's pending-wrap tally and raises its event flag. The flag is qualified by a per-channel mask and drives one shared interrupt line.

The running count is not visible directly. A read of a channel's wrap-tally register returns the tally, clears it, and copies the live count into a snapshot register. The count-value register only ever returns that snapshot. Software must therefore read the wrap tally first and the count value second. A reload of all ones, with the inverse of the snapshot taken as the time, gives a monotonic 32-bit time base.

Top module: `snap_timer_bank`

## Requirements
- R1: After the synchronous active-low reset, every readable register reads 0 except the revision constant, and the interrupt output is 0.
- R2: Block register map. Address 0x00 is the block control, where bit 0 is the block-wide run bit (read/write) and the other bits read 0. Address 0x10 returns the revision constant (default 0x00000102). Channel n (0..3) registers sit at 0x20*n plus these offsets: 0x20 config, 0x24 reload, 0x28 count value, 0x2C wrap tally, 0x30 event flag, 0x34 event clear, 0x38 mask. Any other address reads 0. Writes to 0x10, to count value, to wrap tally, to event flag or to an unmapped address change nothing.
- R3: Config bit 0 is the channel run bit. A channel decrements by exactly one per clock while the block run bit and its own run bit are both 1, and holds its count otherwise.
- R4: A write to reload stores the value. If the channel's run bit is 0 at that write, the count is loaded with the same value. If the run bit is 1, the count is left alone.
- R5: When an enabled channel's count is 0 at a clock edge, the count takes the reload value, the wrap tally increments and event flag bit 0 becomes 1, all at that edge.
- R6: Reading the wrap tally returns the number of wraps since its last read and clears it. A wrap at the same edge as the read leaves the tally at 1.
- R7: A wrap-tally read copies the live count into the snapshot. The count-value register returns that snapshot and does not change between wrap-tally reads.
- R8: Read data appears on `rdata` in the cycle after `rd_en` is sampled high, and is 0 in any cycle that follows no read.
- R9: Writing the event clear register with bit 0 set clears the event flag. A wrap at the same edge wins, and the flag stays 1.
- R10: `irq` is the OR over channels of event flag AND mask bit 0. A mask of 0 keeps a channel from ever asserting `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe, sampled at the rising edge |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, sampled at the rising edge |
| rdata | output | 32 | Registered read data, valid the cycle after rd_en |
| irq | output | 1 | Combined masked interrupt |

## Verification
The clocked properties take for granted that the address, strobes and write data hold known values at every rising edge once reset is released, and that reset is held for at least one edge. The bench meets this by driving every input from defined values at falling edges only and by holding reset low for several cycles before the first access. Random reload values are kept small, so wraps happen often. That makes a wrap landing on the same edge as a wrap-tally read, or as an event clear, a frequent event rather than a rare one.

// File: rtl/snap_timer_pkg.sv
// Shared definitions for the snapshot timer bank.
// Assumes channel register offsets fit in the low five address bits.
package snap_timer_pkg;

    localparam int DATA_W   = 32;
    localparam int STRIDE_B = 5;   // log2 of the per-channel address stride

    typedef enum logic [2:0] {
        REG_CFG,
        REG_RELOAD,
        REG_SNAP,
        REG_WRAPS,
        REG_STAT,
        REG_CLR,
        REG_MASK,
        REG_NONE
    } chan_reg_e;

    // Map the low address bits of a channel window onto a register id.
    function automatic chan_reg_e chan_reg_of(input logic [STRIDE_B-1:0] off);
        case (off)
            5'h00:   return REG_CFG;
            5'h04:   return REG_RELOAD;
            5'h08:   return REG_SNAP;
            5'h0C:   return REG_WRAPS;
            5'h10:   return REG_STAT;
            5'h14:   return REG_CLR;
            5'h18:   return REG_MASK;
            default: return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/snap_timer_decode.sv
// Address decoder for the timer bank.
// Flags the block-level registers and produces a one-hot channel hit
// plus the register id within that channel's window.
// Assumes ADDR_W is wide enough to reach the last channel window.
module snap_timer_decode
    import snap_timer_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_ctrl,
    output logic              hit_rev,
    output logic [NUM_CH-1:0] ch_hit,
    output chan_reg_e         ch_reg
);

    localparam int FIELD_W = ADDR_W - STRIDE_B;
    localparam logic [ADDR_W-1:0] REV_ADDR = ADDR_W'(16);

    logic [FIELD_W-1:0] win;

    // Split the address into window number and in-window register id.
    always_comb begin
        win      = addr[ADDR_W-1:STRIDE_B];
        ch_reg   = chan_reg_of(addr[STRIDE_B-1:0]);
        hit_ctrl = (addr == '0);
        hit_rev  = (addr == REV_ADDR);
    end

    // Window n+1 belongs to channel n.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_hit
        assign ch_hit[i] = (ch_reg != REG_NONE) && (win == FIELD_W'(i + 1));
    end

endmodule

// File: rtl/snap_timer_chan.sv
// One timer channel: down counter with reload, wrap tally that clears on
// read, snapshot capture on the tally read, event flag with mask and clear.
// Assumes hit/reg_id come from the shared decoder for the current address.
module snap_timer_chan
    import snap_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int WRAP_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_en,
    input  logic              hit,
    input  chan_reg_e         reg_id,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_val,
    output logic              irq_req
);

    logic              loc_en;
    logic              mask_q;
    logic              stat_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  reload_q;
    logic [CNT_W-1:0]  snap_q;
    logic [WRAP_W-1:0] wraps_q;

    logic wr_hit, rd_hit, run, wrap_ev, reload_wr, wraps_rd, clr_wr;

    // Qualify strobes for this channel and derive the counting condition.
    always_comb begin
        wr_hit    = wr_en && hit;
        rd_hit    = rd_en && hit;
        run       = glob_en && loc_en;
        wrap_ev   = run && (cnt_q == '0);
        reload_wr = wr_hit && (reg_id == REG_RELOAD);
        wraps_rd  = rd_hit && (reg_id == REG_WRAPS);
        clr_wr    = wr_hit && (reg_id == REG_CLR) && wdata[0];
    end

    // Writable control bits: run bit, mask bit and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_en   <= 1'b0;
            mask_q   <= 1'b0;
            reload_q <= '0;
        end else begin
            if (wr_hit && reg_id == REG_CFG)  loc_en <= wdata[0];
            if (wr_hit && reg_id == REG_MASK) mask_q <= wdata[0];
            if (reload_wr)                    reload_q <= wdata[CNT_W-1:0];
        end
    end

    // Counter: preload while stopped, count down while running, reload at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload_wr && !loc_en) begin
            cnt_q <= wdata[CNT_W-1:0];
        end else if (run) begin
            cnt_q <= wrap_ev ? reload_q : cnt_q - CNT_W'(1);
        end
    end

    // Wrap tally and snapshot: a tally read clears, a wrap on the same edge counts after it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wraps_q <= '0;
            snap_q  <= '0;
        end else if (wraps_rd) begin
            wraps_q <= wrap_ev ? WRAP_W'(1) : '0;
            snap_q  <= cnt_q;
        end else if (wrap_ev) begin
            wraps_q <= wraps_q + WRAP_W'(1);
        end
    end

    // Event flag: set on wrap, cleared by write-one, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       stat_q <= 1'b0;
        else if (wrap_ev) stat_q <= 1'b1;
        else if (clr_wr)  stat_q <= 1'b0;
    end

    // Read value of the addressed register inside this channel.
    always_comb begin
        case (reg_id)
            REG_CFG:    rd_val = DATA_W'(loc_en);
            REG_RELOAD: rd_val = DATA_W'(reload_q);
            REG_SNAP:   rd_val = DATA_W'(snap_q);
            REG_WRAPS:  rd_val = DATA_W'(wraps_q);
            REG_STAT:   rd_val = DATA_W'(stat_q);
            REG_MASK:   rd_val = DATA_W'(mask_q);
            default:    rd_val = '0;
        endcase
    end

    assign irq_req = stat_q && mask_q;

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload_wr) |=> $stable(cnt_q));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != '0 && !reload_wr) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R5
    wrap_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == '0) |=> (cnt_q == $past(reload_q)) && stat_q);

    // R6
    tally_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wraps_rd && !wrap_ev) |=> (wraps_q == '0));

    // R7
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wraps_rd |=> $stable(snap_q));

    // R9
    clear_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !wrap_ev) |=> !stat_q);

endmodule

// File: rtl/snap_timer_bank.sv
// Top of the timer bank: register port, block-wide run bit, revision
// constant, channel array, registered read mux and interrupt combine.
// Assumes a single master; read data returns one cycle after the strobe.
module snap_timer_bank
    import snap_timer_pkg::*;
#(
    parameter int          NUM_CH = 4,
    parameter int          ADDR_W = 8,
    parameter int          CNT_W  = 32,
    parameter logic [31:0] REV    = 32'h0000_0102
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    input  logic              rd_en,
    output logic [31:0]       rdata,
    output logic              irq
);

    logic              glob_en;
    logic              hit_ctrl, hit_rev;
    logic [NUM_CH-1:0] ch_hit;
    logic [NUM_CH-1:0] ch_irq;
    chan_reg_e         ch_reg;
    logic [DATA_W-1:0] ch_val [NUM_CH];
    logic [DATA_W-1:0] ch_rd;

    snap_timer_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .addr     (addr),
        .hit_ctrl (hit_ctrl),
        .hit_rev  (hit_rev),
        .ch_hit   (ch_hit),
        .ch_reg   (ch_reg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        snap_timer_chan #(
            .CNT_W  (CNT_W),
            .WRAP_W (DATA_W)
        ) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .glob_en (glob_en),
            .hit     (ch_hit[i]),
            .reg_id  (ch_reg),
            .wr_en   (wr_en),
            .rd_en   (rd_en),
            .wdata   (wdata),
            .rd_val  (ch_val[i]),
            .irq_req (ch_irq[i])
        );
    end

    // Block-wide run bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                  glob_en <= 1'b0;
        else if (wr_en && hit_ctrl)  glob_en <= wdata[0];
    end

    // Gather the addressed channel's value; at most one channel is hit.
    always_comb begin
        ch_rd = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_hit[i]) ch_rd = ch_rd | ch_val[i];
        end
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n || !rd_en) rdata <= '0;
        else if (hit_ctrl)    rdata <= {31'b0, glob_en};
        else if (hit_rev)     rdata <= REV;
        else                  rdata <= ch_rd;
    end

    assign irq = |ch_irq;

    // R8
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    // R2
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_ctrl && !hit_rev && ch_hit == '0) |=> (rdata == '0));

    // R2
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_ctrl, hit_rev, ch_hit}));

endmodule

// File: tb/test_snap_timer_bank.sv
module test_snap_timer_bank;

    localparam int          NCH = 4;
    localparam logic [31:0] REV = 32'h0000_0102;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    snap_timer_bank i_snap_timer_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .wdata (wdata),
        .rd_en (rd_en),
        .rdata (rdata),
        .irq   (irq)
    );

    // Reference state built from the requirements.
    logic        m_glob;
    logic        m_en   [NCH];
    logic        m_mask [NCH];
    logic        m_stat [NCH];
    logic [31:0] m_rel  [NCH];
    logic [31:0] m_cnt  [NCH];
    logic [31:0] m_wrap [NCH];
    logic [31:0] m_snap [NCH];
    logic [31:0] m_rd;

    function automatic int chan_of(logic [7:0] a);
        logic [4:0] o;
        o = a[4:0];
        if (!(o == 5'h00 || o == 5'h04 || o == 5'h08 || o == 5'h0C ||
              o == 5'h10 || o == 5'h14 || o == 5'h18)) return -1;
        if (a[7:5] >= 3'd1 && a[7:5] <= 3'd4) return int'(a[7:5]) - 1;
        return -1;
    endfunction

    function automatic logic model_irq();
        logic r;
        r = 1'b0;
        for (int i = 0; i < NCH; i++) r = r | (m_stat[i] & m_mask[i]);
        return r;
    endfunction

    function automatic string tag_of(logic r, logic [7:0] a);
        if (!r) return "R8";
        if (chan_of(a) < 0) return "R2";
        case (a[4:0])
            5'h00: return "R3";
            5'h04: return "R4";
            5'h08: return "R7";
            5'h0C: return "R6";
            5'h10: return "R5";
            5'h18: return "R10";
            default: return "R2";
        endcase
    endfunction

    // Reference update at each rising edge.
    always @(posedge clk) begin
        int          c;
        logic [4:0]  o;
        logic [31:0] rv;
        c = chan_of(addr);
        o = addr[4:0];
        rv = '0;
        if (!rst_n) begin
            m_glob <= 1'b0;
            m_rd   <= '0;
            for (int i = 0; i < NCH; i++) begin
                m_en[i] <= 1'b0; m_mask[i] <= 1'b0; m_stat[i] <= 1'b0;
                m_rel[i] <= '0;  m_cnt[i] <= '0;    m_wrap[i] <= '0; m_snap[i] <= '0;
            end
        end else begin
            if (rd_en) begin
                if (addr == 8'h00)      rv = {31'b0, m_glob};
                else if (addr == 8'h10) rv = REV;
                else if (c >= 0) begin
                    case (o)
                        5'h00: rv = {31'b0, m_en[c]};
                        5'h04: rv = m_rel[c];
                        5'h08: rv = m_snap[c];
                        5'h0C: rv = m_wrap[c];
                        5'h10: rv = {31'b0, m_stat[c]};
                        5'h18: rv = {31'b0, m_mask[c]};
                        default: rv = '0;
                    endcase
                end
            end
            m_rd <= rv;
            if (wr_en && addr == 8'h00) m_glob <= wdata[0];
            for (int i = 0; i < NCH; i++) begin
                logic run, wev, hw, hr;
                run = m_glob && m_en[i];
                wev = run && (m_cnt[i] == 0);
                hw  = wr_en && (c == i);
                hr  = rd_en && (c == i);
                if (hw && o == 5'h04 && !m_en[i]) m_cnt[i] <= wdata;
                else if (run) m_cnt[i] <= wev ? m_rel[i] : m_cnt[i] - 1;
                if (hw && o == 5'h04) m_rel[i]  <= wdata;
                if (hw && o == 5'h00) m_en[i]   <= wdata[0];
                if (hw && o == 5'h18) m_mask[i] <= wdata[0];
                if (wev) m_stat[i] <= 1'b1;
                else if (hw && o == 5'h14 && wdata[0]) m_stat[i] <= 1'b0;
                if (hr && o == 5'h0C) begin
                    m_wrap[i] <= wev ? 32'd1 : 32'd0;
                    m_snap[i] <= m_cnt[i];
                end else if (wev) begin
                    m_wrap[i] <= m_wrap[i] + 1;
                end
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive after a falling edge, compare at the next falling edge.
    task automatic step(logic w, logic r, logic [7:0] a, logic [31:0] d, string tag = "");
        wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk((tag == "") ? tag_of(r, a) : tag, rdata, m_rd);
        chk("R10", {31'b0, irq}, {31'b0, model_irq()});
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, 8'h00, '0);
    endtask

    function automatic logic [7:0] ra(int ch, logic [7:0] off);
        return 8'(32 * ch) + off;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        chk("R1", rdata, '0);
        chk("R1", {31'b0, irq}, 32'd0);
        rst_n = 1'b1;

        // R1: everything reads zero after reset (revision aside)
        step(1'b0, 1'b1, 8'h00, '0, "R1");
        step(1'b0, 1'b1, 8'h10, '0, "R2");
        for (int c = 0; c < NCH; c++)
            for (int k = 0; k < 7; k++)
                step(1'b0, 1'b1, ra(c, 8'h20 + 8'(4 * k)), '0, "R1");

        // R2: writes to read-only and unmapped locations change nothing
        step(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 8'h28, 32'h1234_5678);
        step(1'b1, 1'b0, 8'h2C, 32'h0000_0009);
        step(1'b1, 1'b0, 8'h30, 32'h0000_0001);
        step(1'b1, 1'b0, 8'h04, 32'hFFFF_FFFF);
        step(1'b1, 1'b0, 8'hA0, 32'hFFFF_FFFF);
        step(1'b0, 1'b1, 8'h10, '0, "R2");
        step(1'b0, 1'b1, 8'h2C, '0, "R2");
        step(1'b0, 1'b1, 8'h28, '0, "R2");
        step(1'b0, 1'b1, 8'h30, '0, "R2");
        step(1'b0, 1'b1, 8'h04, '0, "R2");
        step(1'b0, 1'b1, 8'h3C, '0, "R2");
        step(1'b0, 1'b1, 8'hA0, '0, "R2");
        step(1'b0, 1'b1, 8'hFC, '0, "R2");

        // R4: preload while stopped, visible after a tally read
        step(1'b1, 1'b0, ra(0, 8'h24), 32'd7);
        step(1'b0, 1'b1, ra(0, 8'h2C), '0, "R6");
        step(1'b0, 1'b1, ra(0, 8'h28), '0, "R4");

        // R3: local run alone does not count
        step(1'b1, 1'b0, ra(0, 8'h20), 32'd1);
        idle(3);
        step(1'b0, 1'b1, ra(0, 8'h2C), '0, "R3");
        step(1'b0, 1'b1, ra(0, 8'h28), '0, "R3");

        // R3/R7: both run bits set, count falls; snapshot holds between tally reads
        step(1'b1, 1'b0, 8'h00, 32'd1);
        idle(2);
        step(1'b0, 1'b1, ra(0, 8'h2C), '0, "R6");
        idle(3);
        step(1'b0, 1'b1, ra(0, 8'h28), '0, "R7");
        step(1'b0, 1'b1, ra(0, 8'h2C), '0, "R6");
        step(1'b0, 1'b1, ra(0, 8'h28), '0, "R3");

        // R4: reload write while running leaves count alone
        step(1'b1, 1'b0, ra(0, 8'h24), 32'd3);
        step(1'b0, 1'b1, ra(0, 8'h2C), '0, "R5");
        step(1'b0, 1'b1, ra(0, 8'h28), '0, "R4");

        // R5/R6/R9/R10: reload 0 wraps every cycle on channel 1
        step(1'b1, 1'b0, ra(1, 8'h24), 32'd0);
        step(1'b1, 1'b0, ra(1, 8'h38), 32'd1);
        step(1'b1, 1'b0, ra(1, 8'h20), 32'd1);
        idle(4);
        step(1'b0, 1'b1, ra(1, 8'h30), '0, "R5");
        step(1'b0, 1'b1, ra(1, 8'h2C), '0, "R6");
        step(1'b0, 1'b1, ra(1, 8'h2C), '0, "R6");
        step(1'b1, 1'b0, ra(1, 8'h34), 32'd1, "R9");
        step(1'b0, 1'b1, ra(1, 8'h30), '0, "R9");
        step(1'b1, 1'b0, ra(1, 8'h20), 32'd0);
        step(1'b1, 1'b0, ra(1, 8'h34), 32'd1, "R9");
        step(1'b0, 1'b1, ra(1, 8'h30), '0, "R9");
        step(1'b0, 1'b1, ra(1, 8'h2C), '0, "R6");

        // R10: flag set but masked keeps irq low
        step(1'b1, 1'b0, ra(2, 8'h24), 32'd1);
        step(1'b1, 1'b0, ra(2, 8'h20), 32'd1);
        idle(4);
        step(1'b0, 1'b1, ra(2, 8'h30), '0, "R5");
        step(1'b1, 1'b0, ra(2, 8'h38), 32'd1, "R10");
        step(1'b1, 1'b0, ra(2, 8'h38), 32'd0, "R10");
        idle(2);

        // Random traffic with small reloads so wraps and collisions recur
        for (int n = 0; n < 6000; n++) begin
            int          kind, ch, k;
            logic [7:0]  a;
            logic [31:0] d;
            kind = int'($urandom % 10);
            ch   = int'($urandom % NCH);
            k    = int'($urandom % 7);
            a    = ra(ch, 8'h20 + 8'(4 * k));
            if ($urandom % 20 == 0) a = 8'($urandom);
            if ($urandom % 25 == 0) a = ($urandom % 2 == 0) ? 8'h00 : 8'h10;
            if (a == 8'h00) d = ($urandom % 8 == 0) ? 32'd0 : 32'd1;
            else if (a[4:0] == 5'h04) d = $urandom % 24;
            else d = $urandom;
            if (kind < 6)       step(1'b0, 1'b1, a, '0);
            else if (kind < 9)  step(1'b1, 1'b0, a, d);
            else                step(1'b1, 1'b1, a, d);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule